// File: doc/BRIEF.md
# SQE Heartbeat Test Pulse Generator

This block produces the heartbeat (signal quality error test) indication that a 10 Mb/s twisted-pair transceiver returns to its MAC after each frame it sends. It watches the MAC transmit enable. When that enable drops, marking the end of a frame, the block waits a programmable number of clock cycles. It then drives a collision pulse of programmable width. Logic outside the block ORs this pulse with the other collision sources.

The test runs only when the port is a node rather than a repeater, runs half duplex, has a valid link, and has its test-inhibit control cleared. The inhibit control resets to zero, so the test is on by default. All mode and control inputs are registered once. A falling edge counts only if the enabling conditions were true on the clock that saw it. A pending or running pulse is dropped as soon as any condition fails. A pending test is also abandoned if transmit enable comes back before the pulse starts.

Top module: `sqe_heartbeat`

## Requirements
- R1: Count as edge 0 the first rising clock edge that samples tx_en_i low after it was sampled high. With all enabling conditions true at edge 0, hb_col_o rises after edge DELAY_CYC+1.
- R2: A pulse that is not cancelled stays high for exactly WIDTH_CYC clock cycles. hb_col_o is then low after edge DELAY_CYC+WIDTH_CYC+1.
- R3: node_mode_i encodes 1 for node and 0 for repeater. With node_mode_i at 0, no pulse is produced.
- R4: half_duplex_i encodes 1 for half duplex and 0 for full duplex. With half_duplex_i at 0, no pulse is produced.
- R5: link_ok_i encodes 1 for a valid link. With link_ok_i at 0 (link failure), no pulse is produced.
- R6: sqe_inhibit_i at 1 blocks the test. At 0 it allows the test.
- R7: The enabling conditions are judged only on their values at edge 0. A condition that becomes true after edge 0 does not start a pulse for that falling edge.
- R8: Suppose one enabling input goes false between edges m and m+1. Then hb_col_o is low from edge m+2 onward, whether the pulse was still pending or already active.
- R9: If tx_en_i goes high between edges m and m+1 with m < DELAY_CYC, the pending pulse is abandoned and no pulse appears. If it goes high later, the pulse runs to completion. The next falling edge of tx_en_i starts a new test.
- R10: hb_col_o is low during reset. It stays low while tx_en_i holds a steady level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | MAC transmit enable |
| node_mode_i | input | 1 | 1 = node, 0 = repeater |
| half_duplex_i | input | 1 | 1 = half duplex, 0 = full duplex |
| link_ok_i | input | 1 | 1 = link valid |
| sqe_inhibit_i | input | 1 | 1 = heartbeat test disabled |
| hb_col_o | output | 1 | Heartbeat collision pulse |

## Verification
The bench builds the block with DELAY_CYC = 3 and WIDTH_CYC = 2. At those values a whole test window spans only a handful of cycles. Every one of the sixteen combinations of the four enabling inputs is therefore swept. The cancel and abort points are also swept over every cycle from the falling edge to past the end of the pulse. This covers the boundary between an abort that lands in the delay and one that lands during the pulse. It also covers a cancel on the first and on the last pulse cycle.

// File: rtl/sqe_hb_pkg.sv
package sqe_hb_pkg;

    typedef enum logic [1:0] {
        HB_IDLE  = 2'd0,
        HB_WAIT  = 2'd1,
        HB_PULSE = 2'd2
    } hb_state_e;

    // Registered copy of the MAC-side and mode inputs
    typedef struct packed {
        logic tx_en;
        logic tx_prev;
        logic allow;
    } hb_in_t;

    function automatic int hb_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sqe_hb_inreg.sv
module sqe_hb_inreg
    import sqe_hb_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tx_en_i,
    input  logic node_mode_i,
    input  logic half_duplex_i,
    input  logic link_ok_i,
    input  logic sqe_inhibit_i,
    output logic tx_en_q_o,
    output logic fall_o,
    output logic allow_o
);

    hb_in_t in_d, in_q;

    always_comb begin
        in_d         = in_q;
        in_d.tx_en   = tx_en_i;
        in_d.tx_prev = in_q.tx_en;
        in_d.allow   = node_mode_i & half_duplex_i & link_ok_i & ~sqe_inhibit_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            in_q <= '0;
        end else begin
            in_q <= in_d;
        end
    end

    // End of frame: registered enable was high one clock ago, low now
    assign tx_en_q_o = in_q.tx_en;
    assign fall_o    = in_q.tx_prev & ~in_q.tx_en;
    assign allow_o   = in_q.allow;

endmodule

// File: rtl/sqe_hb_timer.sv
module sqe_hb_timer
    import sqe_hb_pkg::*;
#(
    parameter int DELAY_CYC = 25,
    parameter int WIDTH_CYC = 25
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tx_en_q_i,
    input  logic fall_i,
    input  logic allow_i,
    output logic pulse_o
);

    localparam int CNT_MAX = hb_max(DELAY_CYC, WIDTH_CYC);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] DELAY_LAST = CNT_W'(DELAY_CYC - 1);
    localparam logic [CNT_W-1:0] WIDTH_LAST = CNT_W'(WIDTH_CYC - 1);

    typedef struct packed {
        hb_state_e        state;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        unique case (tmr_q.state)
            HB_IDLE: begin
                if (fall_i && allow_i) begin
                    tmr_d.state = HB_WAIT;
                    tmr_d.cnt   = '0;
                end
            end
            HB_WAIT: begin
                if (!allow_i || tx_en_q_i) begin
                    // conditions lost or a new frame began: drop the test
                    tmr_d.state = HB_IDLE;
                    tmr_d.cnt   = '0;
                end else if (tmr_q.cnt == DELAY_LAST) begin
                    tmr_d.state = HB_PULSE;
                    tmr_d.cnt   = '0;
                end else begin
                    tmr_d.cnt = tmr_q.cnt + CNT_W'(1);
                end
            end
            HB_PULSE: begin
                if (!allow_i || (tmr_q.cnt == WIDTH_LAST)) begin
                    tmr_d.state = HB_IDLE;
                    tmr_d.cnt   = '0;
                end else begin
                    tmr_d.cnt = tmr_q.cnt + CNT_W'(1);
                end
            end
            default: begin
                tmr_d.state = HB_IDLE;
                tmr_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmr_q <= '{state: HB_IDLE, cnt: '0};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign pulse_o = (tmr_q.state == HB_PULSE);

endmodule

// File: rtl/sqe_heartbeat.sv
module sqe_heartbeat #(
    parameter int DELAY_CYC = 25,
    parameter int WIDTH_CYC = 25
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tx_en_i,
    input  logic node_mode_i,
    input  logic half_duplex_i,
    input  logic link_ok_i,
    input  logic sqe_inhibit_i,
    output logic hb_col_o
);

    logic tx_en_q;
    logic fall;
    logic allow;

    sqe_hb_inreg u_inreg (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .tx_en_i       (tx_en_i),
        .node_mode_i   (node_mode_i),
        .half_duplex_i (half_duplex_i),
        .link_ok_i     (link_ok_i),
        .sqe_inhibit_i (sqe_inhibit_i),
        .tx_en_q_o     (tx_en_q),
        .fall_o        (fall),
        .allow_o       (allow)
    );

    sqe_hb_timer #(
        .DELAY_CYC (DELAY_CYC),
        .WIDTH_CYC (WIDTH_CYC)
    ) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tx_en_q_i (tx_en_q),
        .fall_i    (fall),
        .allow_i   (allow),
        .pulse_o   (hb_col_o)
    );

endmodule

// File: rtl/sqe_heartbeat_chk.sv
module sqe_heartbeat_chk #(
    parameter int WIDTH_CYC = 25
) (
    input logic clk_i,
    input logic rst_ni,
    input logic node_mode_i,
    input logic half_duplex_i,
    input logic link_ok_i,
    input logic sqe_inhibit_i,
    input logic hb_col_o
);

    localparam int RUN_W = $clog2(WIDTH_CYC + 2) + 1;

    logic [RUN_W-1:0] run_len;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_len <= '0;
        end else if (hb_col_o) begin
            if (run_len != '1) run_len <= run_len + RUN_W'(1);
        end else begin
            run_len <= '0;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |=> !hb_col_o); // R10
    AST_PULSE_WIDTH_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni) run_len <= RUN_W'(WIDTH_CYC)); // R2
    AST_REPEATER_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) $past(!node_mode_i, 2) |-> !hb_col_o); // R3
    AST_FULL_DUPLEX_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) $past(!half_duplex_i, 2) |-> !hb_col_o); // R4
    AST_LINK_FAIL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) $past(!link_ok_i, 2) |-> !hb_col_o); // R5
    AST_INHIBIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) $past(sqe_inhibit_i, 2) |-> !hb_col_o); // R6

endmodule

bind sqe_heartbeat sqe_heartbeat_chk #(
    .WIDTH_CYC (WIDTH_CYC)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .node_mode_i   (node_mode_i),
    .half_duplex_i (half_duplex_i),
    .link_ok_i     (link_ok_i),
    .sqe_inhibit_i (sqe_inhibit_i),
    .hb_col_o      (hb_col_o)
);

// File: tb/tb_sqe_heartbeat.sv
module tb_sqe_heartbeat;

    localparam int CLK_PERIOD = 10;
    localparam int D  = 3;
    localparam int W  = 2;
    localparam int WD = 100000;

    logic clk = 1'b0;
    logic rst_ni;
    logic tx_en, node, half, link, inh;
    logic col;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sqe_heartbeat #(.DELAY_CYC(D), .WIDTH_CYC(W)) dut (
        .clk_i         (clk),
        .rst_ni        (rst_ni),
        .tx_en_i       (tx_en),
        .node_mode_i   (node),
        .half_duplex_i (half),
        .link_ok_i     (link),
        .sqe_inhibit_i (inh),
        .hb_col_o      (col)
    );

    task automatic check(input logic got, input logic exp, input string req, input int k);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: hb_col_o actual=%b expected=%b", req, k, got, exp);
        end
    endtask

    // kind: 0 plain, 1 drop link, 2 raise tx_en, 3 raise link late,
    //       4 drop node, 5 drop half duplex, 6 raise inhibit (action after edge m)
    function automatic logic exp_col(input logic en, input int kind, input int m, input int k);
        logic win;
        win = en && (k >= D + 1) && (k <= D + W);
        case (kind)
            0:          return win;
            1, 4, 5, 6: return win && (k <= m + 1);
            2:          return (m <= D - 1) ? 1'b0 : win;
            default:    return 1'b0;
        endcase
    endfunction

    task automatic tx_frame(input logic nd, input logic hd, input logic lk, input logic ih,
                            input int kind, input int m, input string tag);
        logic  en;
        string req;
        en = nd & hd & lk & ~ih;
        if (tag != "")   req = tag;
        else if (en)     req = "R1 R2";
        else if (!nd)    req = "R3";
        else if (!hd)    req = "R4";
        else if (!lk)    req = "R5";
        else             req = "R6";
        @(negedge clk);
        node = nd; half = hd; link = lk; inh = ih; tx_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(col, 1'b0, "R10", -1);
        end
        tx_en = 1'b0;
        for (int k = 0; k <= D + W + 3; k++) begin
            @(negedge clk);
            check(col, exp_col(en, kind, m, k), req, k);
            if (k == m) begin
                case (kind)
                    1: link  = 1'b0;
                    2: tx_en = 1'b1;
                    3: link  = 1'b1;
                    4: node  = 1'b0;
                    5: half  = 1'b0;
                    6: inh   = 1'b1;
                    default: ;
                endcase
            end
        end
        node = 1'b1; half = 1'b1; link = 1'b1; inh = 1'b0;
        for (int i = 0; i < D + W + 2; i++) begin
            @(negedge clk);
            check(col, 1'b0, "R10", -1);
        end
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog: actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_ni = 1'b0;
        tx_en = 1'b0; node = 1'b1; half = 1'b1; link = 1'b1; inh = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(col, 1'b0, "R10", -1);
        end
        rst_ni = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(col, 1'b0, "R10", -1);
        end

        // R1..R6: every combination of the four enabling inputs
        for (int c = 0; c < 16; c++) begin
            tx_frame(c[3], c[2], c[1], c[0], 0, 0, "");
        end

        // R8: cancel by each enabling input at every point of the window
        for (int m = 0; m <= D + W; m++) begin
            tx_frame(1'b1, 1'b1, 1'b1, 1'b0, 1, m, "R8");
            tx_frame(1'b1, 1'b1, 1'b1, 1'b0, 4, m, "R8");
            tx_frame(1'b1, 1'b1, 1'b1, 1'b0, 5, m, "R8");
            tx_frame(1'b1, 1'b1, 1'b1, 1'b0, 6, m, "R8");
        end

        // R9: transmit enable returns before or during the pulse, then re-arm
        for (int m = 0; m <= D + W; m++) begin
            tx_frame(1'b1, 1'b1, 1'b1, 1'b0, 2, m, "R9");
            tx_frame(1'b1, 1'b1, 1'b1, 1'b0, 0, 0, "R9");
        end

        // R7: link becomes valid only after the falling edge was judged
        for (int m = 0; m < 3; m++) begin
            tx_frame(1'b1, 1'b1, 1'b0, 1'b0, 3, m, "R7");
        end

        // R10: long steady levels of transmit enable
        tx_en = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            check(col, 1'b0, "R10", -1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule